// File: doc/BRIEF.md
# Read-While-Write Flash Bank Busy Tracker

This block models the control side of a four-bank NOR flash that can read from one bank while an embedded program or erase runs in another. It turns each word address into a bank index and a sector index, and it remembers which bank and sector hold the active embedded operation. It also remembers whether a sector erase has been suspended. From that state it decides whether each read returns array data or is refused with a status word. It also decides whether each program or erase request starts, is blocked by boot-sector write protection, or is rejected as a sequencing error.

The surrounding controller pulses a read strobe, a program or erase request, a completion pulse from the embedded algorithm, and suspend or resume pulses. All of these share one word address bus. Results for reads and for write requests come back as registered one-cycle pulses. The busy and suspend state is visible continuously.

Top module: `rww_busy_tracker`

## Requirements
- R1: The bank index comes from address bits [21:19]. The value 000 maps to bank 0, values 001 to 011 map to bank 1, values 100 to 110 map to bank 2, and 111 maps to bank 3. The index appears on `rd_bank` with each read result.
- R2: Sectors are numbered upward from address 0. The lowest 32 Kwords form eight 4-Kword sectors, numbered 0 to 7 (from address bits [14:12]). The highest 32 Kwords form eight 4-Kword sectors, numbered 134 to 141. Every other 32-Kword block is one sector, numbered address[21:15] + 7. The number appears on `rd_sector` with each read result.
- R3: A read to a bank with no active embedded operation gives `rd_array`=1 and `rd_stat`=0 in the cycle after the strobe. There is no added wait, even while another bank is busy.
- R4: A read to the busy bank gives `rd_refused`=1 in the cycle after the strobe. It also gives a status word `rd_stat` with bit 0 set for an active program, bit 1 for an active erase and bit 2 for a suspended erase.
- R5: An accepted program or erase request pulses `wr_ack` in the next cycle. It then holds `busy`=1, with `busy_bank` set to the target bank.
- R6: A program or erase request that arrives while an operation is active is ignored and sets `seq_err`. So does an erase request during a suspend, and a program request into the suspended erase sector. `seq_err` stays set until reset.
- R7: While `wp` is 1, program and erase requests to sectors 0, 1, 140 and 141 do not start. Instead they pulse `wr_prot`. While `wp` is 0, those sectors accept requests.
- R8: A suspend pulse during an active erase ends the busy state and sets `erase_suspended`. Afterwards, reads to the suspended bank return array data everywhere except in the erased sector.
- R9: During a suspend, a program request outside the erased sector is accepted, including in the same bank.
- R10: A resume pulse with a suspended erase and no active operation restores `busy`=1 on the erased bank and clears `erase_suspended`.
- R11: A completion pulse ends the active operation. The block then returns to read-array mode for that bank, and a suspended erase stays suspended.
- R12: After reset, `busy`, `erase_suspended`, `seq_err`, and all result pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 22 | Word address shared by all strobes |
| rd_req | input | 1 | Read strobe |
| pgm_req | input | 1 | Program request |
| ers_req | input | 1 | Sector erase request |
| op_done | input | 1 | Completion pulse of the embedded operation |
| susp_req | input | 1 | Erase suspend pulse |
| resume_req | input | 1 | Erase resume pulse |
| wp | input | 1 | Boot-sector write protect, active high |
| rd_array | output | 1 | Read returned array data |
| rd_refused | output | 1 | Read refused, status word returned |
| rd_bank | output | 2 | Bank of the last read |
| rd_sector | output | 8 | Sector of the last read |
| rd_stat | output | 8 | Status word of a refused read |
| wr_ack | output | 1 | Request accepted |
| wr_prot | output | 1 | Request blocked by protection |
| seq_err | output | 1 | Sticky sequencing error |
| busy | output | 1 | An embedded operation is active |
| busy_bank | output | 2 | Bank of the active operation |
| erase_suspended | output | 1 | An erase is suspended |

## Verification
Every read result and every request verdict is registered once. It is therefore due exactly one clock after the strobe cycle. The `busy`, `busy_bank`, `erase_suspended` and `seq_err` outputs come straight from state registers, so they change at that same edge. Stimulus is applied on falling edges. A read driver queues its expected bank, sector, verdict and status word, and a monitor pops the queue on the following falling edge, whenever a read result pulse is high. Request outcomes are sampled at the falling edge after the strobe is dropped.

// File: rtl/rwwt_pkg.sv
package rwwt_pkg;
    localparam int ADDR_W      = 22;
    localparam int BANK_W      = 2;
    localparam int SECT_W      = 8;
    localparam int SEL_HI      = ADDR_W - 1;
    localparam int SEL_LO      = ADDR_W - 3;
    localparam int BIG_LSB     = 15;
    localparam int SMALL_LSB   = 12;
    localparam int BIG_W       = ADDR_W - BIG_LSB;
    localparam int SMALL_W     = BIG_LSB - SMALL_LSB;
    localparam int BOOT_CNT    = 1 << SMALL_W;
    localparam int BIG_CNT     = (1 << BIG_W) - 2;
    localparam int NUM_SECT    = 2 * BOOT_CNT + BIG_CNT;
    localparam int TOP_BASE    = BOOT_CNT + BIG_CNT;
    localparam int STAT_W      = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PGM  = 2'd1,
        OP_ERS  = 2'd2
    } op_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [SECT_W-1:0] sector;
        logic              prot;
    } loc_t;

    function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
        logic [2:0] sel;
        sel = a[SEL_HI:SEL_LO];
        if (sel == 3'd0)       return 2'd0;
        else if (sel <= 3'd3)  return 2'd1;
        else if (sel <= 3'd6)  return 2'd2;
        else                   return 2'd3;
    endfunction

    function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
        logic [BIG_W-1:0] blk;
        blk = a[ADDR_W-1:BIG_LSB];
        if (blk == '0)
            return SECT_W'(a[BIG_LSB-1:SMALL_LSB]);
        else if (blk == '1)
            return SECT_W'(TOP_BASE) + SECT_W'(a[BIG_LSB-1:SMALL_LSB]);
        else
            return SECT_W'(blk) + SECT_W'(BOOT_CNT - 1);
    endfunction

    function automatic logic edge_boot(input logic [SECT_W-1:0] s);
        return (s < SECT_W'(2)) || (s >= SECT_W'(NUM_SECT - 2));
    endfunction
endpackage

// File: rtl/rwwt_decode.sv
module rwwt_decode
    import rwwt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output loc_t              loc
);
    // R1 bank select, R2 sector numbering, R7 outer boot sectors
    always_comb begin
        loc.bank   = bank_of(addr);
        loc.sector = sector_of(addr);
        loc.prot   = edge_boot(loc.sector);
    end
endmodule

// File: rtl/rwwt_op_tracker.sv
module rwwt_op_tracker
    import rwwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  loc_t              loc,
    input  logic              pgm_req,
    input  logic              ers_req,
    input  logic              op_done,
    input  logic              susp_req,
    input  logic              resume_req,
    input  logic              wp,
    output op_e               act,
    output logic [BANK_W-1:0] act_bank,
    output logic              sus_vld,
    output logic [SECT_W-1:0] sus_sector,
    output logic              wr_ack,
    output logic              wr_prot,
    output logic              seq_err
);
    logic [SECT_W-1:0] act_sector;
    logic [BANK_W-1:0] sus_bank;
    logic              req;
    logic              conflict;

    always_comb begin
        req      = pgm_req | ers_req;
        // R6: active op, erase during suspend, or program into the erased sector
        conflict = (act != OP_NONE) ||
                   (sus_vld && (ers_req || (loc.sector == sus_sector)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act        <= OP_NONE;
            act_bank   <= '0;
            act_sector <= '0;
            sus_vld    <= 1'b0;
            sus_bank   <= '0;
            sus_sector <= '0;
            wr_ack     <= 1'b0;
            wr_prot    <= 1'b0;
            seq_err    <= 1'b0;
        end else begin
            wr_ack  <= 1'b0;
            wr_prot <= 1'b0;
            if (op_done) begin
                // R11: back to read-array mode, suspended erase kept
                act <= OP_NONE;
            end else if (susp_req) begin
                if (act == OP_ERS && !sus_vld) begin
                    sus_vld    <= 1'b1;
                    sus_bank   <= act_bank;
                    sus_sector <= act_sector;
                    act        <= OP_NONE;
                end
            end else if (resume_req) begin
                if (sus_vld && act == OP_NONE) begin
                    act        <= OP_ERS;
                    act_bank   <= sus_bank;
                    act_sector <= sus_sector;
                    sus_vld    <= 1'b0;
                end
            end else if (req) begin
                if (conflict) begin
                    seq_err <= 1'b1;
                end else if (wp && loc.prot) begin
                    wr_prot <= 1'b1;
                end else begin
                    act        <= ers_req ? OP_ERS : OP_PGM;
                    act_bank   <= loc.bank;
                    act_sector <= loc.sector;
                    wr_ack     <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rwwt_read_gate.sv
module rwwt_read_gate
    import rwwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  loc_t              loc,
    input  op_e               act,
    input  logic [BANK_W-1:0] act_bank,
    input  logic              sus_vld,
    input  logic [SECT_W-1:0] sus_sector,
    output logic              rd_array,
    output logic              rd_refused,
    output logic [BANK_W-1:0] rd_bank,
    output logic [SECT_W-1:0] rd_sector,
    output logic [STAT_W-1:0] rd_stat
);
    logic              refuse;
    logic [STAT_W-1:0] stat_now;

    always_comb begin
        refuse   = ((act != OP_NONE) && (loc.bank == act_bank)) ||
                   (sus_vld && (loc.sector == sus_sector));
        stat_now = STAT_W'({sus_vld, act == OP_ERS, act == OP_PGM});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_array   <= 1'b0;
            rd_refused <= 1'b0;
            rd_bank    <= '0;
            rd_sector  <= '0;
            rd_stat    <= '0;
        end else begin
            rd_array   <= rd_req && !refuse;
            rd_refused <= rd_req && refuse;
            if (rd_req) begin
                rd_bank   <= loc.bank;
                rd_sector <= loc.sector;
                rd_stat   <= refuse ? stat_now : '0;
            end
        end
    end
endmodule

// File: rtl/rww_busy_tracker.sv
module rww_busy_tracker
    import rwwt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_req,
    input  logic              pgm_req,
    input  logic              ers_req,
    input  logic              op_done,
    input  logic              susp_req,
    input  logic              resume_req,
    input  logic              wp,
    output logic              rd_array,
    output logic              rd_refused,
    output logic [BANK_W-1:0] rd_bank,
    output logic [SECT_W-1:0] rd_sector,
    output logic [STAT_W-1:0] rd_stat,
    output logic              wr_ack,
    output logic              wr_prot,
    output logic              seq_err,
    output logic              busy,
    output logic [BANK_W-1:0] busy_bank,
    output logic              erase_suspended
);
    loc_t              loc;
    op_e               act;
    logic [BANK_W-1:0] act_bank;
    logic              sus_vld;
    logic [SECT_W-1:0] sus_sector;

    rwwt_decode u_dec (
        .addr (addr),
        .loc  (loc)
    );

    rwwt_op_tracker u_trk (
        .clk        (clk),
        .rst        (rst),
        .loc        (loc),
        .pgm_req    (pgm_req),
        .ers_req    (ers_req),
        .op_done    (op_done),
        .susp_req   (susp_req),
        .resume_req (resume_req),
        .wp         (wp),
        .act        (act),
        .act_bank   (act_bank),
        .sus_vld    (sus_vld),
        .sus_sector (sus_sector),
        .wr_ack     (wr_ack),
        .wr_prot    (wr_prot),
        .seq_err    (seq_err)
    );

    rwwt_read_gate u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_req     (rd_req),
        .loc        (loc),
        .act        (act),
        .act_bank   (act_bank),
        .sus_vld    (sus_vld),
        .sus_sector (sus_sector),
        .rd_array   (rd_array),
        .rd_refused (rd_refused),
        .rd_bank    (rd_bank),
        .rd_sector  (rd_sector),
        .rd_stat    (rd_stat)
    );

    assign busy            = (act != OP_NONE);
    assign busy_bank       = act_bank;
    assign erase_suspended = sus_vld;
endmodule

// File: rtl/rwwt_checker.sv
module rwwt_checker
    import rwwt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              rd_req,
    input logic              pgm_req,
    input logic              ers_req,
    input logic              op_done,
    input logic              susp_req,
    input logic              resume_req,
    input logic              wp,
    input logic              rd_array,
    input logic              rd_refused,
    input logic [BANK_W-1:0] rd_bank,
    input logic [SECT_W-1:0] rd_sector,
    input logic [STAT_W-1:0] rd_stat,
    input logic              wr_ack,
    input logic              wr_prot,
    input logic              seq_err,
    input logic              busy,
    input logic [BANK_W-1:0] busy_bank,
    input logic              erase_suspended
);
    logic quiet_ctl;
    assign quiet_ctl = !op_done && !susp_req && !resume_req;

    assert_busy_refuse_R4: assert property (@(posedge clk) disable iff (rst)
        rd_req && busy && (bank_of(addr) == busy_bank) |=> rd_refused);

    assert_ack_busy_R5: assert property (@(posedge clk) disable iff (rst)
        wr_ack |-> busy);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> seq_err);

    assert_protect_R7: assert property (@(posedge clk) disable iff (rst)
        (pgm_req || ers_req) && wp && quiet_ctl && !busy && !erase_suspended &&
        edge_boot(sector_of(addr)) |=> wr_prot && !busy);

    assert_resume_R10: assert property (@(posedge clk) disable iff (rst)
        resume_req && !op_done && !susp_req && erase_suspended && !busy
        |=> busy && !erase_suspended);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        op_done && busy |=> !busy);

    assert_read_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rd_array && !rd_refused);
endmodule

bind rww_busy_tracker rwwt_checker u_chk (.*);

// File: tb/tb_rww_busy_tracker.sv
module tb_rww_busy_tracker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] addr = '0;
    logic        rd_req = 0, pgm_req = 0, ers_req = 0, op_done = 0;
    logic        susp_req = 0, resume_req = 0, wp = 0;
    logic        rd_array, rd_refused, wr_ack, wr_prot, seq_err, busy, erase_suspended;
    logic [1:0]  rd_bank, busy_bank;
    logic [7:0]  rd_sector, rd_stat;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    typedef struct {
        logic [18:0] word;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    rww_busy_tracker dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: queue expected {array, bank, sector, status}
    task automatic do_read(input logic [21:0] a, input logic arr, input logic [1:0] bk,
                           input logic [7:0] sc, input logic [7:0] st, input string tag);
        exp_t e;
        @(negedge clk);
        addr = a;
        rd_req = 1'b1;
        e.word = {arr, bk, sc, st};
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    // monitor: result due one clock after the strobe
    always @(negedge clk) begin
        if (!rst && (rd_array || rd_refused)) begin
            if (q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL R3 unexpected read result actual=%0h expected=none",
                         {rd_array, rd_bank, rd_sector, rd_stat});
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, 32'({rd_array, rd_bank, rd_sector, rd_stat}), 32'(e.word));
                chk({e.tag, " refused flag"}, 32'(rd_refused), 32'(!e.word[18]));
            end
        end
    end

    // which: 0 program, 1 erase, 2 done, 3 suspend, 4 resume
    task automatic strobe(input int which, input logic [21:0] a);
        @(negedge clk);
        addr = a;
        pgm_req    = (which == 0);
        ers_req    = (which == 1);
        op_done    = (which == 2);
        susp_req   = (which == 3);
        resume_req = (which == 4);
        @(negedge clk);
        pgm_req = 0; ers_req = 0; op_done = 0; susp_req = 0; resume_req = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 reset flags", {busy, erase_suspended, seq_err, rd_array, rd_refused, wr_ack, wr_prot},
            7'b0);

        // R1 R2 R3 idle reads across banks
        do_read(22'h005000, 1, 2'd0, 8'd5,   8'h00, "R2 boot low sector 5");
        do_read(22'h008000, 1, 2'd0, 8'd8,   8'h00, "R2 first big sector");
        do_read(22'h0A3000, 1, 2'd1, 8'd27,  8'h00, "R1 bank1 read");
        do_read(22'h2C0000, 1, 2'd2, 8'd95,  8'h00, "R1 bank2 read");
        do_read(22'h3F7FFF, 1, 2'd3, 8'd133, 8'h00, "R2 last big sector");
        do_read(22'h3F9000, 1, 2'd3, 8'd135, 8'h00, "R2 top boot sector");

        // R5 erase start in bank 2
        strobe(1, 22'h2C0000);
        chk("R5 ack", 32'(wr_ack), 1);
        chk("R5 busy bank", {busy, busy_bank}, {1'b1, 2'd2});

        // R4 refused reads, R3 read while erasing elsewhere
        do_read(22'h2C0000, 0, 2'd2, 8'd95, 8'h02, "R4 erased bank refused");
        do_read(22'h280000, 0, 2'd2, 8'd87, 8'h02, "R4 other sector same bank refused");
        do_read(22'h0A3000, 1, 2'd1, 8'd27, 8'h00, "R3 read while write");

        // R6 second request ignored
        strobe(0, 22'h000000);
        chk("R6 ignored no ack", 32'(wr_ack), 0);
        chk("R6 error set", 32'(seq_err), 1);
        chk("R6 busy unchanged", {busy, busy_bank}, {1'b1, 2'd2});

        // R8 suspend
        strobe(3, 22'h000000);
        chk("R8 suspended", {busy, erase_suspended}, 2'b01);
        do_read(22'h2C0000, 0, 2'd2, 8'd95, 8'h04, "R8 erased sector refused");
        do_read(22'h2C8000, 1, 2'd2, 8'd96, 8'h00, "R8 neighbour sector readable");

        // R9 program during suspend
        strobe(0, 22'h2C8000);
        chk("R9 program accepted", {wr_ack, busy, busy_bank}, {1'b1, 1'b1, 2'd2});
        do_read(22'h0A3000, 1, 2'd1, 8'd27, 8'h00, "R3 read during nested program");
        strobe(2, 22'h000000);
        chk("R11 program done keeps suspend", {busy, erase_suspended}, 2'b01);
        strobe(0, 22'h2C1000);
        chk("R9 program into erased sector rejected", {wr_ack, busy}, 2'b00);
        chk("R6 error still set", 32'(seq_err), 1);

        // R10 resume
        strobe(4, 22'h000000);
        chk("R10 resumed", {busy, busy_bank, erase_suspended}, {1'b1, 2'd2, 1'b0});
        do_read(22'h2C8000, 0, 2'd2, 8'd96, 8'h02, "R10 bank busy again");

        // R11 completion
        strobe(2, 22'h000000);
        chk("R11 idle", {busy, erase_suspended}, 2'b00);
        do_read(22'h2C0000, 1, 2'd2, 8'd95, 8'h00, "R11 read array again");

        // R7 write protect
        wp = 1'b1;
        strobe(1, 22'h001000);
        chk("R7 sector1 blocked", {wr_prot, wr_ack, busy}, 3'b100);
        strobe(0, 22'h3FE000);
        chk("R7 sector140 blocked", {wr_prot, wr_ack, busy}, 3'b100);
        strobe(1, 22'h002000);
        chk("R7 sector2 open", {wr_prot, wr_ack, busy, busy_bank}, {3'b011, 2'd0});
        strobe(2, 22'h000000);
        wp = 1'b0;
        strobe(1, 22'h000000);
        chk("R7 sector0 open without wp", {wr_prot, wr_ack, busy}, 3'b011);
        strobe(2, 22'h000000);
        chk("R11 final idle", 32'(busy), 0);

        repeat (3) @(negedge clk);
        chk("R3 all reads answered", 32'(q.size()), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule